// File: doc/BRIEF.md
# Triggered Sample Capture Controller

This block sits on a stream of 16-bit sample words that arrive under a valid/data handshake. It stores a window of that stream into an on-chip buffer, and the window begins only after a defined trigger has occurred. When `start` is pulsed, the controller first writes zero to every buffer location. It then arms and watches the upper byte of each valid word for a high-amplitude level event. A programmable number of these events is passed over, and the event after them is accepted as the trigger.

After the trigger, the block drops a programmable number of further valid words. It then writes consecutive valid words to the buffer from address 0 up to the last address. When the last address is written it raises `done`. Both skip counts are measured in valid words, not in clock cycles, so gaps in the stream stretch the timing but do not change which words are stored.

The buffer write port (enable, address, data) is driven combinationally from the current state and the incoming word. The buffer memory itself sits outside the block.

Top module: `trig_capture_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `busy`, `done` and `wr_en` are low.
- R2: A `start` pulse while idle or done makes `busy` high on the next cycle and `done` low. The block then writes data 0 to addresses 0 through DEPTH-1, one per cycle on DEPTH consecutive cycles, before it arms.
- R3: A valid word is a level event when its bits 15:8, read as an unsigned number, are 240 or more. A value of 239 is not an event.
- R4: While armed, the block passes over `evt_skip` level events and accepts the trigger on event number `evt_skip`+1. The word that completes the trigger is not stored.
- R5: After the trigger, the next `smp_skip` valid words are dropped. When `smp_skip` is 0, the first valid word after the trigger word is stored.
- R6: Cycles with `in_valid` low do not count as events, do not count as dropped words and are not stored.
- R7: While capturing, each valid word is written in its own cycle (`wr_en` high, `wr_data` equal to `in_data`) to the next address in sequence, starting at 0. Exactly DEPTH words are stored in a run.
- R8: After address DEPTH-1 is written, `done` goes high and `busy` goes low. `done` holds until the next `start`.
- R9: `start` is ignored while `busy` is high. The skip counts are sampled only when a run is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when idle or done |
| evt_skip | input | EVT_W | Number of level events to pass over |
| smp_skip | input | SKIP_W | Number of valid words to drop after the trigger |
| in_valid | input | 1 | Sample word qualifier |
| in_data | input | 16 | Sample word |
| wr_en | output | 1 | Buffer write enable |
| wr_addr | output | $clog2(DEPTH) | Buffer write address |
| wr_data | output | 16 | Buffer write data |
| busy | output | 1 | Run in progress (clear, arm, skip, capture) |
| done | output | 1 | Buffer full, held until next start |

## Verification
The bench drives an upper byte of exactly 239 ahead of one of exactly 240. A comparator that is off by one either triggers early, which stores the wrong words, or never triggers, so `done` never rises. Runs with several events to pass over and a nonzero drop count, with idle gaps between words, catch a controller that counts events wrongly, counts idle cycles, or stores the trigger word; any of these shifts the captured contents against the bench's own model. A `start` pulsed in the middle of a capture, with different counts, catches a controller that restarts while busy. The bench also counts every write enable in a run, so stray writes during the skip phase or on idle cycles are caught as well.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int SAMPLE_W = 16;
    localparam int HALF_W   = SAMPLE_W / 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_ARM,
        ST_SKIP,
        ST_CAPTURE,
        ST_DONE
    } cap_state_e;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } cap_sample_t;

    function automatic logic at_or_above(input logic [HALF_W-1:0] v,
                                         input logic [HALF_W-1:0] thr);
        return v >= thr;
    endfunction

endpackage

// File: rtl/cap_level_detect.sv
module cap_level_detect
    import cap_pkg::*;
#(
    parameter logic [HALF_W-1:0] LEVEL = 8'd240
) (
    input  logic        valid,
    input  cap_sample_t smp,
    output logic        hit
);
    always_comb hit = valid && at_or_above(smp.hi, LEVEL);
endmodule

// File: rtl/cap_count.sv
module cap_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= '0;
        else if (inc)
            q <= q + W'(1);
    end
endmodule

// File: rtl/trig_capture_ctrl.sv
module trig_capture_ctrl
    import cap_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int EVT_W  = 8,
    parameter int SKIP_W = 24,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [EVT_W-1:0]    evt_skip,
    input  logic [SKIP_W-1:0]   smp_skip,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_data,
    output logic                wr_en,
    output logic [AW-1:0]       wr_addr,
    output logic [SAMPLE_W-1:0] wr_data,
    output logic                busy,
    output logic                done
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    cap_state_e          state, state_nx;
    logic [EVT_W-1:0]    evt_lim;
    logic [SKIP_W-1:0]   skip_lim;
    logic [AW-1:0]       addr_q;
    logic [EVT_W-1:0]    evt_q;
    logic [SKIP_W-1:0]   skp_q;
    logic                addr_clr, addr_inc;
    logic                evt_clr, evt_inc;
    logic                skp_clr, skp_inc;
    logic                hit;
    logic                launch;
    cap_sample_t         smp;

    assign smp    = cap_sample_t'(in_data);
    assign launch = start && (state == ST_IDLE || state == ST_DONE);

    cap_level_detect #(.LEVEL(8'd240)) u_detect (
        .valid (in_valid),
        .smp   (smp),
        .hit   (hit)
    );

    cap_count #(.W(AW)) u_addr (
        .clk (clk), .rst (rst), .clr (addr_clr), .inc (addr_inc), .q (addr_q)
    );

    cap_count #(.W(EVT_W)) u_evt (
        .clk (clk), .rst (rst), .clr (evt_clr), .inc (evt_inc), .q (evt_q)
    );

    cap_count #(.W(SKIP_W)) u_skp (
        .clk (clk), .rst (rst), .clr (skp_clr), .inc (skp_inc), .q (skp_q)
    );

    always_comb begin
        state_nx = state;
        addr_clr = 1'b0;
        addr_inc = 1'b0;
        evt_clr  = 1'b0;
        evt_inc  = 1'b0;
        skp_clr  = 1'b0;
        skp_inc  = 1'b0;
        wr_en    = 1'b0;
        wr_data  = '0;
        if (launch) begin
            state_nx = ST_CLEAR;
            addr_clr = 1'b1;
            evt_clr  = 1'b1;
            skp_clr  = 1'b1;
        end else begin
            unique case (state)
                ST_CLEAR: begin
                    wr_en = 1'b1;
                    if (addr_q == LAST_ADDR) begin
                        addr_clr = 1'b1;
                        state_nx = ST_ARM;
                    end else begin
                        addr_inc = 1'b1;
                    end
                end
                ST_ARM: begin
                    if (hit) begin
                        if (evt_q == evt_lim)
                            state_nx = (skip_lim == '0) ? ST_CAPTURE : ST_SKIP;
                        else
                            evt_inc = 1'b1;
                    end
                end
                ST_SKIP: begin
                    if (in_valid) begin
                        if (skp_q == skip_lim - SKIP_W'(1))
                            state_nx = ST_CAPTURE;
                        else
                            skp_inc = 1'b1;
                    end
                end
                ST_CAPTURE: begin
                    if (in_valid) begin
                        wr_en   = 1'b1;
                        wr_data = in_data;
                        if (addr_q == LAST_ADDR) begin
                            addr_clr = 1'b1;
                            state_nx = ST_DONE;
                        end else begin
                            addr_inc = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            evt_lim  <= '0;
            skip_lim <= '0;
        end else begin
            state <= state_nx;
            if (launch) begin
                evt_lim  <= evt_skip;
                skip_lim <= smp_skip;
            end
        end
    end

    assign wr_addr = addr_q;
    assign busy    = (state == ST_CLEAR) || (state == ST_ARM) ||
                     (state == ST_SKIP)  || (state == ST_CAPTURE);
    assign done    = (state == ST_DONE);

endmodule

// File: rtl/trig_capture_chk.sv
module trig_capture_chk
    import cap_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                wr_en,
    input logic [AW-1:0]       wr_addr,
    input logic [SAMPLE_W-1:0] wr_data,
    input logic                busy,
    input logic                done,
    input cap_state_e          state
);
    logic [AW-1:0] exp_addr;

    always_ff @(posedge clk) begin
        if (rst)
            exp_addr <= '0;
        else if (wr_en)
            exp_addr <= (exp_addr == AW'(DEPTH - 1)) ? '0 : exp_addr + AW'(1);
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!busy && !done)); // R1
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CLEAR) |-> (wr_en && wr_data == '0)); // R2
    AST_ADDR_SEQ: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr == exp_addr)); // R7
    AST_WRITE_BUSY: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy); // R7
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy && done)); // R8
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done); // R8
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy || done)); // R9

endmodule

bind trig_capture_ctrl trig_capture_chk #(.DEPTH(DEPTH), .AW(AW)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .busy    (busy),
    .done    (done),
    .state   (state)
);

// File: tb/trig_capture_ctrl_tb_top.sv
module trig_capture_ctrl_tb_top;

    localparam int DEPTH  = 16;
    localparam int EVT_W  = 8;
    localparam int SKIP_W = 16;
    localparam int AW     = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [EVT_W-1:0]  evt_skip = '0;
    logic [SKIP_W-1:0] smp_skip = '0;
    logic              in_valid = 1'b0;
    logic [15:0]       in_data = '0;
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic [15:0]       wr_data;
    logic              busy;
    logic              done;

    int n_tests = 0;
    int n_fail  = 0;

    logic [15:0] mem     [DEPTH];
    logic [15:0] exp_mem [DEPTH];
    int          wr_cnt;

    int m_ph, m_ev, m_sk, m_addr, m_elim, m_slim;

    always #5 clk = ~clk;

    trig_capture_ctrl #(.DEPTH(DEPTH), .EVT_W(EVT_W), .SKIP_W(SKIP_W)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .evt_skip (evt_skip),
        .smp_skip (smp_skip),
        .in_valid (in_valid),
        .in_data  (in_data),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .busy     (busy),
        .done     (done)
    );

    always @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
            wr_cnt       <= wr_cnt + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_start(input int e, input int s);
        for (int i = 0; i < DEPTH; i++) mem[i] = 16'hDEAD;
        @(negedge clk);
        evt_skip = EVT_W'(e);
        smp_skip = SKIP_W'(s);
        start    = 1'b1;
        wr_cnt   = 0;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after start", busy, 1);
        check("R2 done low after start", done, 0);
        m_ph = 0; m_ev = 0; m_sk = 0; m_addr = 0; m_elim = e; m_slim = s;
        repeat (DEPTH) @(negedge clk);
        begin
            int nz = 0;
            for (int i = 0; i < DEPTH; i++) if (mem[i] !== 16'h0) nz++;
            check("R2 buffer cleared", nz, 0);
        end
        check("R2 clear write count", wr_cnt, DEPTH);
    endtask

    task automatic model(input logic [15:0] w);
        if (m_ph == 0) begin
            if (w[15:8] >= 8'd240) begin
                if (m_ev == m_elim) m_ph = (m_slim == 0) ? 2 : 1;
                else m_ev++;
            end
        end else if (m_ph == 1) begin
            m_sk++;
            if (m_sk == m_slim) m_ph = 2;
        end else if (m_ph == 2) begin
            exp_mem[m_addr] = w;
            m_addr++;
            if (m_addr == DEPTH) m_ph = 3;
        end
    endtask

    task automatic push(input logic [15:0] w, input int gap, input logic st);
        in_valid = 1'b1;
        in_data  = w;
        start    = st;
        evt_skip = st ? 8'd5 : evt_skip;
        smp_skip = st ? 16'd7 : smp_skip;
        model(w);
        @(negedge clk);
        in_valid = 1'b0;
        start    = 1'b0;
        in_data  = 16'h5A5A;
        repeat (gap) @(negedge clk);
    endtask

    task automatic finish_check(input string tag);
        @(negedge clk);
        check({tag, " R8 done"}, done, 1);
        check({tag, " R8 busy low"}, busy, 0);
        check({tag, " R7 total writes"}, wr_cnt, 2 * DEPTH);
        begin
            int bad = 0;
            for (int i = 0; i < DEPTH; i++) if (mem[i] !== exp_mem[i]) bad++;
            check({tag, " R7 buffer contents mismatches"}, bad, 0);
        end
        repeat (5) @(negedge clk);
        check({tag, " R8 done held"}, done, 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 wr_en", wr_en, 0);
    endtask

    task automatic t_basic();
        do_start(0, 0);
        push(16'h10AA, 0, 0);
        push(16'hEF01, 1, 0);
        push(16'hF077, 0, 0);   // trigger word, not stored (R4, R5)
        for (int k = 0; k < 200 && m_ph != 3; k++)
            push({8'(k) ^ 8'hF5, 8'(k)}, 0, 0);
        finish_check("basic R3 R4 R5");
    endtask

    task automatic t_counts();
        do_start(2, 3);
        for (int k = 0; k < 400 && m_ph != 3; k++)
            push({(k % 3 == 0) ? 8'hFF : 8'h40, 8'(k)}, k % 3, 0);   // R6 gaps
        finish_check("counts R4 R5 R6");
    endtask

    task automatic t_start_busy();
        do_start(1, 0);
        for (int k = 0; k < 400 && m_ph != 3; k++)
            push({(k % 2 == 0) ? 8'hF8 : 8'h11, 8'(k + 3)}, 0, (k == 9));   // R9
        finish_check("start ignored R9");
    endtask

    task automatic t_boundary();
        do_start(0, 1);
        for (int k = 0; k < 6; k++) push({8'd239, 8'(k)}, 0, 0);
        push({8'd240, 8'h00}, 0, 0);
        for (int k = 0; k < 200 && m_ph != 3; k++)
            push({8'd239, 8'(k + 40)}, 0, 0);
        finish_check("level boundary R3");
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        wr_cnt = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_counts();
        t_start_busy();
        t_boundary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule